// File: doc/BRIEF.md
# Extended Register Unlock Key and CRTC Write Guard

This block sits beside the register file of a VGA-compatible display controller and watches its I/O write stream. Two byte-wide ports (a compatibility port and a mode port) form a lock: the value last written to the compatibility port decides how a write to the mode port affects a single key flag. The key flag is brought out so other logic can gate its extended features.

The block also filters writes to the CRTC data port. It latches the CRTC index from the index port. For each data write it decides whether the register file may commit the write and what byte it stores. It applies two rules. The first is the classic timing write-protect, controlled by bit 7 of CRTC register 0x11. The second is the extended-register lock, controlled by the key. A masked exception lets bit 4 of register 7 change while the other bits of that register are protected. The block also owns the decode enable of the alternate compatibility port 0x3BF, which follows bit 0 of the miscellaneous output register.

The accept strobe, index and value are combinational from the write in progress, so the register file commits the write in the same cycle.

Top module: `vga_xreg_lock`

## Requirements
- R1: After reset the key output is 0, the alternate-port enable is 0, the stored compatibility byte is 0x00 and the write-protect state is clear.
- R2: A write to port 0x3DF, or to port 0x3BF while that port is enabled, stores the byte as the compatibility byte. Such a write never raises the CRTC accept strobe.
- R3: A write to port 0x3D8 sets the key on the next cycle when the stored compatibility byte is 0x03 and bits 7 and 5 of the written byte are both 1.
- R4: A write to port 0x3D8 clears the key on the next cycle when the stored compatibility byte is not 0x03 and bits 7 and 5 of the written byte are not both 1.
- R5: The key is unchanged by a 0x3D8 write that meets neither condition, and by every write to any other port.
- R6: A write to port 0x3D4 latches the CRTC index. An allowed write to port 0x3D5 raises the accept strobe in the same cycle, with the latched index and the stored value.
- R7: While the write-protect state is set, writes to CRTC indices 0x00 through 0x06 and to index 0x35 are dropped (no accept strobe).
- R8: While the key is 0, writes to CRTC indices above 0x18 are dropped, except writes to indices 0x33 and 0x35.
- R9: While the write-protect state is set, an accepted write to index 0x07 stores bit 4 of the written byte and bits 7:5 and 3:0 of the current register-7 input.
- R10: The alternate-port enable takes bit 0 of each byte written to port 0x3C2, starting on the next cycle. While the enable is 0, writes to 0x3BF have no effect.
- R11: The write-protect state takes bit 7 of each accepted write to CRTC index 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O port address |
| io_data | input | 8 | I/O write data |
| crtc_r7_now | input | 8 | Current content of CRTC register 7 from the register file |
| key_on | output | 1 | Extended-register key flag |
| alt_port_en | output | 1 | Decode enable for port 0x3BF |
| crtc_we | output | 1 | CRTC write accepted |
| crtc_idx | output | 8 | Index of the accepted write |
| crtc_wdata | output | 8 | Value to store |

## Verification
The hardest case to reach is a key update through the alternate port 0x3BF. The port must first be opened by a miscellaneous-register write, and only then can it load the compatibility byte that gates the mode-port write. The stimulus therefore writes 0x03 to 0x3BF while the port is closed and shows that the key does not move. It then opens the port, repeats the write and sets the key. Later it closes the port again and shows that a write which would change the compatibility byte is ignored. The write-protect cases are reached only after register 0x11 has been written through the filter itself. For that reason the bench sets and clears protection through ordinary index and data writes, and it does so both with the key held and with the key released.

// File: rtl/vxl_pkg.sv
package vxl_pkg;
   localparam logic [15:0] PORT_ALT_COMPAT = 16'h03BF;
   localparam logic [15:0] PORT_COMPAT     = 16'h03DF;
   localparam logic [15:0] PORT_MODE       = 16'h03D8;
   localparam logic [15:0] PORT_CRTC_IDX   = 16'h03D4;
   localparam logic [15:0] PORT_CRTC_DAT   = 16'h03D5;
   localparam logic [15:0] PORT_MISC       = 16'h03C2;

   typedef struct packed {
      logic compat;
      logic mode;
      logic idx;
      logic data;
      logic misc;
   } port_hit_t;
endpackage

// File: rtl/vxl_port_decode.sv
module vxl_port_decode
   import vxl_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter bit ALT_GATED  = 1'b1,
   parameter int MISC_BIT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_data,
   output port_hit_t         hit,
   output logic              alt_en
);
   localparam logic [ADDR_W-1:0] A_ALT  = ADDR_W'(PORT_ALT_COMPAT);
   localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(PORT_COMPAT);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(PORT_MODE);
   localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(PORT_CRTC_IDX);
   localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(PORT_CRTC_DAT);
   localparam logic [ADDR_W-1:0] A_MISC = ADDR_W'(PORT_MISC);

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("vxl_port_decode: ADDR_W must be at least 12");
      end
      if (MISC_BIT >= DATA_W) begin : g_bad_bit
         $error("vxl_port_decode: MISC_BIT outside data width");
      end
   endgenerate

   logic alt_q;

   generate
      if (ALT_GATED) begin : g_gated
         always_ff @(posedge clk) begin
            if (!rst_n)
               alt_q <= 1'b0;
            else if (io_wr && io_addr == A_MISC)
               alt_q <= io_data[MISC_BIT];
         end
      end else begin : g_open
         always_ff @(posedge clk) begin
            if (!rst_n)
               alt_q <= 1'b1;
            else
               alt_q <= 1'b1;
         end
      end
   endgenerate

   assign alt_en = alt_q;

   always_comb begin
      hit.compat = io_wr && ((io_addr == A_CMP) || (alt_q && io_addr == A_ALT));
      hit.mode   = io_wr && (io_addr == A_MODE);
      hit.idx    = io_wr && (io_addr == A_IDX);
      hit.data   = io_wr && (io_addr == A_DAT);
      hit.misc   = io_wr && (io_addr == A_MISC);
   end

   generate
      if (ALT_GATED) begin : g_chk
         assert_alt_follow_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            hit.misc |=> (alt_en == $past(io_data[MISC_BIT])));
         assert_alt_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            !hit.misc |=> $stable(alt_en));
      end
   endgenerate
endmodule

// File: rtl/vxl_key_seq.sv
module vxl_key_seq
   import vxl_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] KEY_CMP   = 8'h03,
   parameter logic [DATA_W-1:0] MODE_MASK = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_hit_t         hit,
   input  logic [DATA_W-1:0] io_data,
   output logic              key
);
   generate
      if (MODE_MASK == '0) begin : g_bad_mask
         $error("vxl_key_seq: MODE_MASK must select at least one bit");
      end
   endgenerate

   logic [DATA_W-1:0] cmp_q;
   logic              key_q;
   logic              cmp_match;
   logic              mode_full;

   assign cmp_match = (cmp_q == KEY_CMP);
   assign mode_full = ((io_data & MODE_MASK) == MODE_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
         key_q <= 1'b0;
      end else begin
         if (hit.compat)
            cmp_q <= io_data;
         if (hit.mode) begin
            if (cmp_match && mode_full)
               key_q <= 1'b1;
            else if (!cmp_match && !mode_full)
               key_q <= 1'b0;
         end
      end
   end

   assign key = key_q;

   assert_key_set_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (hit.mode && cmp_q == KEY_CMP && (io_data & MODE_MASK) == MODE_MASK) |=> key);
   assert_key_clear_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (hit.mode && cmp_q != KEY_CMP && (io_data & MODE_MASK) != MODE_MASK) |=> !key);
   assert_key_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !hit.mode |=> $stable(key));
   assert_cmp_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      hit.compat |=> (cmp_q == $past(io_data)));
endmodule

// File: rtl/vxl_crtc_guard.sv
module vxl_crtc_guard
   import vxl_pkg::*;
#(
   parameter int                       IDX_W     = 8,
   parameter int                       DATA_W    = 8,
   parameter logic [IDX_W-1:0]         TIMING_TOP = 8'h06,
   parameter logic [IDX_W-1:0]         PROT_IDX  = 8'h11,
   parameter int                       PROT_BIT  = 7,
   parameter logic [IDX_W-1:0]         PROT_XTRA = 8'h35,
   parameter logic [IDX_W-1:0]         LAST_STD  = 8'h18,
   parameter int                       N_OPEN    = 2,
   parameter logic [N_OPEN*IDX_W-1:0]  OPEN_LIST = {8'h35, 8'h33},
   parameter logic [IDX_W-1:0]         MASK_IDX  = 8'h07,
   parameter logic [DATA_W-1:0]        MASK_FREE = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_hit_t         hit,
   input  logic [DATA_W-1:0] io_data,
   input  logic              key,
   input  logic [DATA_W-1:0] r7_now,
   output logic              we,
   output logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] wdata
);
   generate
      if (PROT_BIT >= DATA_W) begin : g_bad_pbit
         $error("vxl_crtc_guard: PROT_BIT outside data width");
      end
      if (N_OPEN < 1) begin : g_bad_open
         $error("vxl_crtc_guard: N_OPEN must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic             prot_q;
   logic [N_OPEN-1:0] open_vec;
   logic             open_hit;
   logic             timing_lock;
   logic             ext_lock;
   logic             allow;
   logic [DATA_W-1:0] val;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (hit.idx)
         idx_q <= io_data[IDX_W-1:0];
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_OPEN; gi++) begin : g_open
         assign open_vec[gi] = (idx_q == OPEN_LIST[gi*IDX_W +: IDX_W]);
      end
   endgenerate

   assign open_hit    = |open_vec;
   assign timing_lock = prot_q && ((idx_q <= TIMING_TOP) || (idx_q == PROT_XTRA));
   assign ext_lock    = !key && (idx_q > LAST_STD) && !open_hit;
   assign allow       = hit.data && !timing_lock && !ext_lock;

   always_comb begin
      if (prot_q && idx_q == MASK_IDX)
         val = (r7_now & ~MASK_FREE) | (io_data & MASK_FREE);
      else
         val = io_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         prot_q <= 1'b0;
      else if (allow && idx_q == PROT_IDX)
         prot_q <= val[PROT_BIT];
   end

   assign we    = allow;
   assign idx   = idx_q;
   assign wdata = val;

   assert_prot_drop_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q && (idx <= TIMING_TOP || idx == PROT_XTRA)) |-> !we);
   assert_lock_drop_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!key && idx > LAST_STD && !open_hit) |-> !we);
   assert_mask_keep_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && prot_q && idx == MASK_IDX) |-> ((wdata & ~MASK_FREE) == (r7_now & ~MASK_FREE)));
   assert_we_source_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      we |-> hit.data);
   assert_prot_track_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == PROT_IDX) |=> (prot_q == $past(wdata[PROT_BIT])));
endmodule

// File: rtl/vga_xreg_lock.sv
module vga_xreg_lock
   import vxl_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int IDX_W     = 8,
   parameter bit ALT_GATED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_data,
   input  logic [DATA_W-1:0] crtc_r7_now,
   output logic              key_on,
   output logic              alt_port_en,
   output logic              crtc_we,
   output logic [IDX_W-1:0]  crtc_idx,
   output logic [DATA_W-1:0] crtc_wdata
);
   generate
      if (IDX_W > DATA_W) begin : g_bad_idx
         $error("vga_xreg_lock: IDX_W may not exceed DATA_W");
      end
   endgenerate

   port_hit_t hit;
   logic      key;

   vxl_port_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ALT_GATED (ALT_GATED),
      .MISC_BIT  (0)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_wr   (io_wr),
      .io_addr (io_addr),
      .io_data (io_data),
      .hit     (hit),
      .alt_en  (alt_port_en)
   );

   vxl_key_seq #(
      .DATA_W    (DATA_W),
      .KEY_CMP   (DATA_W'(8'h03)),
      .MODE_MASK (DATA_W'(8'hA0))
   ) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .io_data (io_data),
      .key     (key)
   );

   vxl_crtc_guard #(
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W)
   ) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .io_data (io_data),
      .key     (key),
      .r7_now  (crtc_r7_now),
      .we      (crtc_we),
      .idx     (crtc_idx),
      .wdata   (crtc_wdata)
   );

   assign key_on = key;

   assert_no_crtc_on_other_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr != ADDR_W'(PORT_CRTC_DAT)) |-> !crtc_we);
endmodule

// File: tb/vga_xreg_lock_bench.sv
module vga_xreg_lock_bench;
   localparam int PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0] io_data = '0;
   logic [7:0] r7_now = 8'hA5;
   logic       key_on, alt_port_en, crtc_we;
   logic [7:0] crtc_idx, crtc_wdata;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct packed {
      logic       we;
      logic [7:0] idx;
      logic [7:0] val;
   } exp_t;
   exp_t  exp_q[$];
   string tag_q[$];

   always #(PER/2) clk = ~clk;

   vga_xreg_lock u_vga_xreg_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .io_wr       (io_wr),
      .io_addr     (io_addr),
      .io_data     (io_data),
      .crtc_r7_now (r7_now),
      .key_on      (key_on),
      .alt_port_en (alt_port_en),
      .crtc_we     (crtc_we),
      .crtc_idx    (crtc_idx),
      .crtc_wdata  (crtc_wdata)
   );

   // Monitor: samples mid-cycle while a write is held on the inputs.
   always @(negedge clk) begin
      if (rst_n && io_wr) begin
         if (io_addr == 16'h03D5) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_bad++;
               $display("FAIL R6: data write with no expectation, we=%0b", crtc_we);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               n_chk++;
               if (crtc_we !== e.we ||
                   (e.we && (crtc_idx !== e.idx || crtc_wdata !== e.val))) begin
                  n_bad++;
                  $display("FAIL %s: we=%0b idx=%02h val=%02h expected we=%0b idx=%02h val=%02h",
                           t, crtc_we, crtc_idx, crtc_wdata, e.we, e.idx, e.val);
               end
            end
         end else begin
            n_chk++;
            if (crtc_we !== 1'b0) begin
               n_bad++;
               $display("FAIL R2: crtc_we=%0b on port %04h expected 0", crtc_we, io_addr);
            end
         end
      end
   end

   task automatic io_put(input logic [15:0] a, input logic [7:0] d);
      @(posedge clk); #(PER/4);
      io_wr = 1'b1; io_addr = a; io_data = d;
      @(posedge clk); #(PER/4);
      io_wr = 1'b0;
   endtask

   task automatic crtc_put(input logic [7:0] i, input logic [7:0] d,
                           input logic ok, input logic [7:0] v, input string t);
      io_put(16'h03D4, i);
      exp_q.push_back('{we: ok, idx: i, val: v});
      tag_q.push_back(t);
      io_put(16'h03D5, d);
   endtask

   task automatic chk_bit(input logic act, input logic exp, input string t);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", t, act, exp);
      end
   endtask

   initial begin : watchdog
      #(PER*20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #(PER/4) rst_n = 1'b1;
      @(posedge clk); #(PER/4);
      // R1 reset state
      chk_bit(key_on, 1'b0, "R1 key");
      chk_bit(alt_port_en, 1'b0, "R1 alt");
      chk_bit(crtc_we, 1'b0, "R1 we");

      // R6 plain accepted write; R8 lock with key clear
      crtc_put(8'h02, 8'h5A, 1'b1, 8'h5A, "R6");
      crtc_put(8'h18, 8'h3C, 1'b1, 8'h3C, "R8 last std");
      crtc_put(8'h19, 8'h11, 1'b0, 8'h00, "R8 locked 0x19");
      crtc_put(8'h20, 8'h22, 1'b0, 8'h00, "R8 locked 0x20");
      crtc_put(8'h33, 8'h44, 1'b1, 8'h44, "R8 open 0x33");
      crtc_put(8'h35, 8'h55, 1'b1, 8'h55, "R8 open 0x35");

      // R10 port 0x3BF closed: compat stays 0, mode A0 holds key at 0
      io_put(16'h03BF, 8'h03);
      io_put(16'h03D8, 8'hA0);
      chk_bit(key_on, 1'b0, "R10 closed alt port");
      io_put(16'h03C2, 8'h01);
      chk_bit(alt_port_en, 1'b1, "R10 enable");
      io_put(16'h03BF, 8'h03);
      io_put(16'h03D8, 8'hA0);
      chk_bit(key_on, 1'b1, "R3 set via alt port");

      // R5 holds
      io_put(16'h03D8, 8'h20);
      chk_bit(key_on, 1'b1, "R5 compat match, partial mode");
      io_put(16'h03DF, 8'h01);
      io_put(16'h03D8, 8'hE0);
      chk_bit(key_on, 1'b1, "R5 compat mismatch, full mode");
      io_put(16'h03D8, 8'h80);
      chk_bit(key_on, 1'b0, "R4 clear");
      io_put(16'h03D8, 8'hA0);
      chk_bit(key_on, 1'b0, "R5 hold clear");

      // R3 via port 0x3DF, then extended access
      io_put(16'h03DF, 8'h03);
      io_put(16'h03D8, 8'hA0);
      chk_bit(key_on, 1'b1, "R3 set via 0x3DF");
      crtc_put(8'h20, 8'h66, 1'b1, 8'h66, "R8 key open 0x20");

      // R11 protect on; R7 and R9
      crtc_put(8'h11, 8'h80, 1'b1, 8'h80, "R11 protect on");
      crtc_put(8'h00, 8'h12, 1'b0, 8'h00, "R7 idx 0");
      crtc_put(8'h06, 8'h12, 1'b0, 8'h00, "R7 idx 6");
      crtc_put(8'h35, 8'h12, 1'b0, 8'h00, "R7 idx 0x35");
      crtc_put(8'h33, 8'h77, 1'b1, 8'h77, "R7 idx 0x33 passes");
      crtc_put(8'h07, 8'hFF, 1'b1, 8'hB5, "R9 set bit4");
      r7_now = 8'h5A;
      crtc_put(8'h07, 8'h00, 1'b1, 8'h4A, "R9 clear bit4");
      crtc_put(8'h08, 8'hC3, 1'b1, 8'hC3, "R7 idx 8 passes");

      // R10 close port again: 0x3BF write ignored
      io_put(16'h03C2, 8'h00);
      chk_bit(alt_port_en, 1'b0, "R10 disable");
      io_put(16'h03BF, 8'h00);
      io_put(16'h03D8, 8'h00);
      chk_bit(key_on, 1'b1, "R10 ignored 0x3BF kept compat");
      io_put(16'h03DF, 8'h00);
      io_put(16'h03D8, 8'h00);
      chk_bit(key_on, 1'b0, "R4 clear again");

      // R11 protect off releases timing registers and register 7
      crtc_put(8'h11, 8'h7F, 1'b1, 8'h7F, "R11 protect off");
      crtc_put(8'h05, 8'h9E, 1'b1, 8'h9E, "R11 idx 5 free");
      crtc_put(8'h07, 8'h0F, 1'b1, 8'h0F, "R11 idx 7 full");
      crtc_put(8'h35, 8'h01, 1'b1, 8'h01, "R8 idx 0x35 open");

      @(posedge clk); #(PER/4);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R6: %0d expected writes unseen, expected 0", exp_q.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule